// File: doc/BRIEF.md
# Command Ring Register Bank

This block is the 16-bit register file that software uses to set up and watch a command ring buffer kept in system memory. Each of the eight 32-bit ring pointers is split into a low and a high 16-bit half at adjacent word addresses. The pointers are: ring start, ring end, upper threshold, lower threshold, fill distance, producer pointer, consumer pointer and stop-point. The full 32-bit values are exported to the pointer-advance and interrupt logic that sits beside the bank.

Writes to pointer halves are masked when they are stored. Low halves keep 32-byte alignment. High halves are cut to the physical address width, and that width depends on a platform-mode input. The bank also holds several other registers:

- a freely writable marker register,
- a control register, whose write raises a one-cycle strobe,
- a clear register,
- a read-only status word, captured every cycle from the neighbouring logic,
- four read-only clip-rectangle words,
- a block of constant metric words.

Reads are registered. An access to an address with no register returns zero and raises an error strobe.

Top module: `cmdq_reg_bank`

## Requirements
- R1: After reset, every pointer half, the control, clear and marker registers read 0. The status word reads 0x000C (both idle bits set). No read returns an error.
- R2: A write to a pointer low half (even word address 0x00 to 0x0E) stores the data ANDed with 0xFFE0, so bits 4:0 always read as 0.
- R3: A write to a pointer high half (odd word address 0x01 to 0x0F) stores the data ANDed with 0x03FF when `wide_addr` is 0, and with 0x1FFF when it is 1. The mask is applied at write time; a later change of `wide_addr` does not alter stored values.
- R4: The marker register at 0x13 stores all 16 written bits.
- R5: The clip-rectangle words at 0x18 to 0x1B (left, top, right, bottom) read 0, 0, 640 and 480, and ignore writes.
- R6: The metric words at 0x20 to 0x2E ignore writes. They read 0, except 0x2E, which reads 4.
- R7: The status word at 0x10 ignores writes. It reads `stat_flags` registered once, in bits 4:0: bit0 upper-threshold exceeded, bit1 below lower threshold, bit2 read idle, bit3 command idle, bit4 stop-point hit.
- R8: The performance-select word at 0x14 reads 0, and a write to it changes no register.
- R9: A write to the control register at 0x11 shows on `ctrl_q` one cycle later. `ctrl_wr_pulse` is high for exactly that cycle per write.
- R10: A read of any other address returns 0 and raises `bus_err`.
- R11: `bus_rdata` and `bus_err` update one cycle after `bus_rd`. `bus_err` is 0 in cycles that follow no read.
- R12: `ptr_flat[32*p+31:32*p]` holds pointer p, with low half at word 2p and high half at word 2p+1. p runs 0 start, 1 end, 2 upper threshold, 3 lower threshold, 4 distance, 5 producer, 6 consumer, 7 stop-point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_addr | input | 1 | Platform mode: 1 selects the 29-bit physical address, 0 the 26-bit one |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | Unmapped-read strobe |
| stat_flags | input | 5 | Live status flags from the FIFO logic |
| ptr_flat | output | 256 | All eight 32-bit pointers |
| ctrl_q | output | 16 | Control register |
| clear_q | output | 16 | Clear register |
| token_q | output | 16 | Marker register |
| ctrl_wr_pulse | output | 1 | One-cycle strobe after a control write |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never raised in the same cycle, and that `wide_addr` is steady in any cycle that writes a pointer high half. The stimulus drives only one strobe at a time. It changes the mode only at a falling edge between accesses, so every write sees one settled mask.

// File: rtl/cmdq_regs_pkg.sv
package cmdq_regs_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 6;
    localparam int NUM_PTR  = 8;
    localparam int NUM_HALF = 2 * NUM_PTR;
    localparam int FLAG_W   = 5;

    localparam logic [DATA_W-1:0] LO_MASK        = 16'hFFE0;
    localparam logic [DATA_W-1:0] HI_MASK_NARROW = 16'h03FF;
    localparam logic [DATA_W-1:0] HI_MASK_WIDE   = 16'h1FFF;

    localparam logic [ADDR_W-1:0] A_STATUS = 6'h10;
    localparam logic [ADDR_W-1:0] A_CTRL   = 6'h11;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 6'h12;
    localparam logic [ADDR_W-1:0] A_TOKEN  = 6'h13;
    localparam logic [ADDR_W-1:0] A_PERF   = 6'h14;

    localparam logic [DATA_W-1:0] STATUS_RST  = 16'h000C;
    localparam logic [3:0]        METRIC_CPV  = 4'hE;
    localparam logic [DATA_W-1:0] CPV_VALUE   = 16'd4;

    typedef enum logic [3:0] {
        K_NONE, K_PTR, K_STATUS, K_CTRL, K_CLEAR, K_TOKEN, K_PERF, K_CLIP, K_METRIC
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] idx;
    } dec_t;

    function automatic logic [DATA_W-1:0] hi_mask(input logic wide);
        return wide ? HI_MASK_WIDE : HI_MASK_NARROW;
    endfunction

    function automatic logic [DATA_W-1:0] clip_value(input logic [1:0] sel);
        case (sel)
            2'd2:    return 16'd640;
            2'd3:    return 16'd480;
            default: return 16'd0;
        endcase
    endfunction
endpackage

// File: rtl/cmdq_addr_decode.sv
module cmdq_addr_decode
    import cmdq_regs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    always_comb begin
        dec.kind = K_NONE;
        dec.idx  = addr[3:0];
        if (addr < ADDR_W'(NUM_HALF)) begin
            dec.kind = K_PTR;
        end else if (addr[5:2] == 4'b0110) begin
            dec.kind = K_CLIP;
        end else if (addr[5:4] == 2'b10 && addr[3:0] != 4'hF) begin
            dec.kind = K_METRIC;
        end else begin
            case (addr)
                A_STATUS: dec.kind = K_STATUS;
                A_CTRL:   dec.kind = K_CTRL;
                A_CLEAR:  dec.kind = K_CLEAR;
                A_TOKEN:  dec.kind = K_TOKEN;
                A_PERF:   dec.kind = K_PERF;
                default:  dec.kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cmdq_ptr_half.sv
module cmdq_ptr_half
    import cmdq_regs_pkg::*;
#(
    parameter bit IS_HI = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              wide,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] mask;

    generate
        if (IS_HI) begin : g_hi
            assign mask = hi_mask(wide);
        end else begin : g_lo
            assign mask = LO_MASK;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata & mask;
    end

    // R3
    half_store_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> q == ($past(wdata) & (IS_HI ? hi_mask($past(wide)) : LO_MASK)));
endmodule

// File: rtl/cmdq_read_mux.sv
module cmdq_read_mux
    import cmdq_regs_pkg::*;
(
    input  dec_t                       dec,
    input  logic [NUM_HALF*DATA_W-1:0] halves,
    input  logic [DATA_W-1:0]          status,
    input  logic [DATA_W-1:0]          ctrl,
    input  logic [DATA_W-1:0]          clear,
    input  logic [DATA_W-1:0]          token,
    output logic [DATA_W-1:0]          data,
    output logic                       hit
);
    always_comb begin
        data = '0;
        hit  = 1'b1;
        case (dec.kind)
            K_PTR:    data = halves[dec.idx*DATA_W +: DATA_W];
            K_STATUS: data = status;
            K_CTRL:   data = ctrl;
            K_CLEAR:  data = clear;
            K_TOKEN:  data = token;
            K_PERF:   data = '0;
            K_CLIP:   data = clip_value(dec.idx[1:0]);
            K_METRIC: data = (dec.idx == METRIC_CPV) ? CPV_VALUE : '0;
            default:  hit  = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmdq_reg_bank.sv
module cmdq_reg_bank
    import cmdq_regs_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wide_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [5:0]                bus_addr,
    input  logic [15:0]               bus_wdata,
    output logic [15:0]               bus_rdata,
    output logic                      bus_err,
    input  logic [4:0]                stat_flags,
    output logic [255:0]              ptr_flat,
    output logic [15:0]               ctrl_q,
    output logic [15:0]               clear_q,
    output logic [15:0]               token_q,
    output logic                      ctrl_wr_pulse
);
    dec_t                       dec;
    logic [NUM_HALF*DATA_W-1:0] halves;
    logic [DATA_W-1:0]          status_q;
    logic [DATA_W-1:0]          rd_data;
    logic                       rd_hit;

    cmdq_addr_decode u_dec (.addr(bus_addr), .dec(dec));

    genvar h;
    generate
        for (h = 0; h < NUM_HALF; h++) begin : g_half
            cmdq_ptr_half #(.IS_HI(h % 2 == 1)) u_half (
                .clk   (clk),
                .rst   (rst),
                .we    (bus_wr && dec.kind == K_PTR && dec.idx == 4'(h)),
                .wide  (wide_addr),
                .wdata (bus_wdata),
                .q     (halves[h*DATA_W +: DATA_W])
            );
        end
    endgenerate

    assign ptr_flat = halves;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q        <= '0;
            clear_q       <= '0;
            token_q       <= '0;
            status_q      <= STATUS_RST;
            ctrl_wr_pulse <= 1'b0;
        end else begin
            status_q      <= {{(DATA_W-FLAG_W){1'b0}}, stat_flags};
            ctrl_wr_pulse <= bus_wr && dec.kind == K_CTRL;
            if (bus_wr && dec.kind == K_CTRL)  ctrl_q  <= bus_wdata;
            if (bus_wr && dec.kind == K_CLEAR) clear_q <= bus_wdata;
            if (bus_wr && dec.kind == K_TOKEN) token_q <= bus_wdata;
        end
    end

    cmdq_read_mux u_mux (
        .dec    (dec),
        .halves (halves),
        .status (status_q),
        .ctrl   (ctrl_q),
        .clear  (clear_q),
        .token  (token_q),
        .data   (rd_data),
        .hit    (rd_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= bus_rd && !rd_hit;
            if (bus_rd) bus_rdata <= rd_data;
        end
    end

    // R9
    ctrl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr_pulse |-> ctrl_q == $past(bus_wdata));

    // R10
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> bus_rdata == '0);

    // R11
    err_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_rd));

    // R2
    genvar p;
    generate
        for (p = 0; p < NUM_PTR; p++) begin : g_align
            lo_align_chk: assert property (@(posedge clk) disable iff (rst)
                ptr_flat[p*32 +: 5] == 5'd0);
        end
    endgenerate

    // R7
    status_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_STATUS) |=> status_q == 16'($past(stat_flags)));
endmodule

// File: tb/cmdq_reg_bank_tb_top.sv
module cmdq_reg_bank_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wide_addr = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [15:0]  bus_wdata = '0;
    logic [15:0]  bus_rdata;
    logic         bus_err;
    logic [4:0]   stat_flags = 5'b01100;
    logic [255:0] ptr_flat;
    logic [15:0]  ctrl_q, clear_q, token_q;
    logic         ctrl_wr_pulse;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cmdq_reg_bank dut_i (
        .clk(clk), .rst(rst), .wide_addr(wide_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .stat_flags(stat_flags), .ptr_flat(ptr_flat), .ctrl_q(ctrl_q), .clear_q(clear_q),
        .token_q(token_q), .ctrl_wr_pulse(ctrl_wr_pulse)
    );

    // {wr, wide, addr[5:0], wdata[15:0], expected read[15:0]}
    localparam int NV = 15;
    localparam logic [39:0] VEC [NV] = '{
        {1'b1, 1'b0, 6'h00, 16'hFFFF, 16'hFFE0},   // R2 start lo
        {1'b1, 1'b0, 6'h01, 16'hFFFF, 16'h03FF},   // R3 start hi narrow
        {1'b1, 1'b1, 6'h03, 16'hFFFF, 16'h1FFF},   // R3 end hi wide
        {1'b0, 1'b0, 6'h03, 16'h0000, 16'h1FFF},   // R3 mode change keeps value
        {1'b1, 1'b1, 6'h0F, 16'hA5A5, 16'h05A5},   // R3 stop-point hi
        {1'b1, 1'b0, 6'h0E, 16'h1234, 16'h1220},   // R2 stop-point lo
        {1'b1, 1'b0, 6'h09, 16'h7FFF, 16'h03FF},   // R3 distance hi
        {1'b1, 1'b0, 6'h13, 16'hBEEF, 16'hBEEF},   // R4 marker
        {1'b1, 1'b0, 6'h1A, 16'h0000, 16'd640},    // R5 clip right
        {1'b1, 1'b0, 6'h1B, 16'h1111, 16'd480},    // R5 clip bottom
        {1'b1, 1'b0, 6'h18, 16'h5555, 16'd0},      // R5 clip left
        {1'b1, 1'b0, 6'h2E, 16'h0000, 16'd4},      // R6 clocks per vertex
        {1'b1, 1'b0, 6'h20, 16'hFFFF, 16'd0},      // R6 metric zero
        {1'b1, 1'b0, 6'h14, 16'hFFFF, 16'd0},      // R8 perf select
        {1'b1, 1'b0, 6'h12, 16'h00FF, 16'h00FF}    // clear register
    };
    localparam int VREQ [NV] = '{2, 3, 3, 3, 3, 2, 3, 4, 5, 5, 5, 6, 6, 8, 4};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [5:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 16; i++) begin
            do_read(6'(i));
            check("R1 pointer half", bus_rdata, 0);
        end
        do_read(6'h10); check("R1 status", bus_rdata, 16'h000C);
        check("R1 no error", bus_err, 0);
        check("R1 ctrl/clear/token", {ctrl_q, clear_q, token_q}, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            wide_addr = VEC[v][38];
            if (VEC[v][39]) do_write(VEC[v][37:32], VEC[v][31:16]);
            do_read(VEC[v][37:32]);
            check($sformatf("R%0d vector %0d", VREQ[v], v), bus_rdata, VEC[v][15:0]);
        end
        check("R4 clear port", clear_q, 16'h00FF);
        check("R4 token port", token_q, 16'hBEEF);
        check("R8 no register changed", {ctrl_q, clear_q, token_q}, {16'h0, 16'h00FF, 16'hBEEF});

        // R12 pointer export
        check("R12 start", ptr_flat[31:0], 32'h03FF_FFE0);
        check("R12 end", ptr_flat[63:32], 32'h1FFF_0000);
        check("R12 distance", ptr_flat[159:128], 32'h03FF_0000);
        check("R12 stop-point", ptr_flat[255:224], 32'h05A5_1220);

        // R7 status capture and write rejection
        stat_flags = 5'b10011;
        do_write(6'h10, 16'hFFFF);
        do_read(6'h10);
        check("R7 status", bus_rdata, 16'h0013);

        // R9 control write pulse
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'h11; bus_wdata = 16'h00A5;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R9 ctrl value", ctrl_q, 16'h00A5);
        check("R9 pulse high", ctrl_wr_pulse, 1);
        @(negedge clk);
        check("R9 pulse one cycle", ctrl_wr_pulse, 0);
        do_read(6'h11);
        check("R9 ctrl readback", bus_rdata, 16'h00A5);

        // R10 / R11 unmapped reads
        do_read(6'h3F);
        check("R10 unmapped data", bus_rdata, 0);
        check("R10 error strobe", bus_err, 1);
        @(negedge clk);
        check("R11 error clears", bus_err, 0);
        do_read(6'h2F);
        check("R10 metric gap", {bus_err, bus_rdata}, {1'b1, 16'h0});
        do_read(6'h13);
        check("R11 mapped read", {bus_err, bus_rdata}, {1'b0, 16'hBEEF});

        finish_up();
    end
endmodule